// File: doc/BRIEF.md
# Masked Internal Control Register Bank

This block holds a processor's internal control registers. Privileged move-to and move-from instructions reach it through one access port. The port carries a six-bit register index, a read strobe, a write strobe and 64-bit write data. Each access returns read data and an access-fault flag one clock later. Every index belongs to one class: general scratch, masked, read-only, write-only or unassigned. The class decides what a read or a write does. A faulting access changes no state, and the core turns the flag into an unimplemented-opcode trap.

The masked registers store only the bits their per-register mask allows. Two of them, the exception summary and exception mask registers, collect event bits from hardware, and any write clears them. The cycle-count register stores only its upper bits. A read of it returns those upper bits with the live value of a free-running counter in the low bits. The read-only registers show live hardware status. A write to a translation-buffer invalidate index stores nothing. Instead it issues a one-cycle command strobe, with an opcode and the written value, to the translation buffers outside this block.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After synchronous reset, every stored register and the cycle counter are zero, and `acc_rdata`, `acc_fault` and `tlb_cmd_valid` are low.
- R2: Indices 0 to NUM_SCR-1 are scratch registers that store and return all 64 bits.
- R3: Masked registers store `wdata & mask`: 0x10 and 0x11 keep 0xf; 0x12 keeps 0x18; 0x13 keeps 0xff_ffff_0300; 0x14 and 0x15 keep 0xffff_ffff_c000_0000; 0x16 keeps 0x1ffb; 0x17 and 0x18 keep 0x3f; 0x19 keeps 0x7f0; 0x1A keeps 0xfe00_0000_0000_0000.
- R4: Index 0x1B (exception summary) and index 0x1C (exception mask) OR in `exc_sum_set` and `exc_mask_set` every cycle. A write clears the register to zero whatever the data. Set bits that arrive in the same cycle as the write are kept.
- R5: Index 0x1D (cycle count) stores only the bits at and above CNT_LO_W. A read returns those bits ORed with the low CNT_LO_W bits of a counter. The counter is zero on the first clock after reset, adds one every clock and wraps.
- R6: Indices 0x20 to 0x23 are read-only. A read returns the live 64-bit slice `ro_status[(i-0x20)*64 +: 64]` sampled at the read strobe. A write raises `acc_fault`.
- R7: Indices 0x28 to 0x2C and 0x30 to 0x35 are write-only. A write is accepted without fault. A read raises `acc_fault` and returns zero.
- R8: A write to index 0x30 to 0x35 drives `tlb_cmd_valid` high for exactly the next cycle. In that cycle `tlb_cmd_op` equals the index minus 0x30 (0 data all, 1 data process, 2 data single, 3 instruction all, 4 instruction process, 5 instruction single) and `tlb_cmd_data` equals the written value.
- R9: Every other index, including scratch indices at or above NUM_SCR, faults on both read and write. Such an access changes no register.
- R10: `acc_rdata` and `acc_fault` are registered. They are valid in the cycle after the strobe. `acc_fault` is a one-cycle pulse, and `acc_rdata` holds until the next read.
- R11: When a read and a write to the same index arrive in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_idx | input | 6 | Register index |
| acc_wdata | input | 64 | Write data |
| exc_sum_set | input | 64 | Event bits ORed into the exception summary register |
| exc_mask_set | input | 64 | Event bits ORed into the exception mask register |
| ro_status | input | 256 | Live values of the four read-only registers |
| acc_rdata | output | 64 | Read data, one cycle after the read strobe |
| acc_fault | output | 1 | Access fault, one cycle after the faulting strobe |
| tlb_cmd_valid | output | 1 | Translation-buffer command strobe |
| tlb_cmd_op | output | 3 | Translation-buffer command opcode |
| tlb_cmd_data | output | 64 | Value written with the command |

## Verification
The bench builds the bank with NUM_SCR = 4 and CNT_LO_W = 8. With four scratch slots, indices 4 to 15 fall into the unassigned range and are checked for faults. With an eight-bit counter field, the counter wraps within a few hundred cycles, so the splice across the wrap and the upper-bit-only write of the cycle-count register can both be checked. Under that configuration the bench sweeps all 64 indices with three data patterns and computes every expected value from the masks and class rules. It then checks the clear-on-write race, the simultaneous read and write, and the width of the fault and command pulses.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int DW = 64;
    localparam int IW = 6;

    typedef logic [DW-1:0] word_t;
    typedef logic [IW-1:0] idx_t;

    // index map
    localparam int MSK_BASE = 16;
    localparam int NUM_MSK  = 14;
    localparam int RO_BASE  = 32;
    localparam int NUM_RO   = 4;
    localparam int WO_BASE  = 40;
    localparam int NUM_WO   = 5;
    localparam int TLB_BASE = 48;
    localparam int NUM_TLB  = 6;

    // masked slots (slot = index - MSK_BASE)
    localparam int SL_EXC_SUM  = 11;
    localparam int SL_EXC_MASK = 12;
    localparam int SL_CYCLE    = 13;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_SCR,
        CLS_MASK,
        CLS_RO,
        CLS_WO
    } cls_e;

    typedef enum logic [2:0] {
        TLB_D_ALL  = 3'd0,
        TLB_D_PROC = 3'd1,
        TLB_D_ONE  = 3'd2,
        TLB_I_ALL  = 3'd3,
        TLB_I_PROC = 3'd4,
        TLB_I_ONE  = 3'd5
    } tlb_op_e;

    typedef struct packed {
        cls_e    cls;
        logic [3:0] slot;
        logic    is_tlb;
        tlb_op_e op;
    } dec_t;

    // bits each masked slot keeps on a write
    function automatic word_t slot_mask(input int s, input int lo_w);
        word_t m;
        case (s)
            0, 1:    m = 64'h0000_0000_0000_000f;
            2:       m = 64'h0000_0000_0000_0018;
            3:       m = 64'h0000_00ff_ffff_0300;
            4, 5:    m = 64'hffff_ffff_c000_0000;
            6:       m = 64'h0000_0000_0000_1ffb;
            7, 8:    m = 64'h0000_0000_0000_003f;
            9:       m = 64'h0000_0000_0000_07f0;
            10:      m = 64'hfe00_0000_0000_0000;
            11, 12:  m = '1;
            13:      m = ~((64'd1 << lo_w) - 64'd1);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/crb_decode.sv
module crb_decode
    import crb_pkg::*;
#(
    parameter int NUM_SCR = 4
) (
    input  idx_t idx,
    output dec_t dec
);
    int ii;
    assign ii = int'(idx);

    always_comb begin
        dec.cls    = CLS_NONE;
        dec.slot   = '0;
        dec.is_tlb = 1'b0;
        dec.op     = TLB_D_ALL;
        if (ii < NUM_SCR) begin
            dec.cls  = CLS_SCR;
            dec.slot = idx[3:0];
        end else if (ii >= MSK_BASE && ii < MSK_BASE + NUM_MSK) begin
            dec.cls  = CLS_MASK;
            dec.slot = 4'(ii - MSK_BASE);
        end else if (ii >= RO_BASE && ii < RO_BASE + NUM_RO) begin
            dec.cls  = CLS_RO;
            dec.slot = 4'(ii - RO_BASE);
        end else if (ii >= WO_BASE && ii < WO_BASE + NUM_WO) begin
            dec.cls  = CLS_WO;
            dec.slot = 4'(ii - WO_BASE);
        end else if (ii >= TLB_BASE && ii < TLB_BASE + NUM_TLB) begin
            dec.cls    = CLS_WO;
            dec.slot   = 4'(ii - TLB_BASE);
            dec.is_tlb = 1'b1;
            dec.op     = tlb_op_e'(3'(ii - TLB_BASE));
        end
    end
endmodule

// File: rtl/crb_cycle_ctr.sv
module crb_cycle_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/crb_store.sv
module crb_store
    import crb_pkg::*;
#(
    parameter int NUM_SCR  = 4,
    parameter int CNT_LO_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ok,
    input  cls_e       wr_cls,
    input  logic [3:0] wr_slot,
    input  word_t      wr_data,
    input  word_t      sum_set,
    input  word_t      mask_set,
    output word_t      scr_q [NUM_SCR],
    output word_t      msk_q [NUM_MSK]
);
    for (genvar s = 0; s < NUM_SCR; s++) begin : g_scr
        word_t q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else if (wr_ok && wr_cls == CLS_SCR && wr_slot == 4'(s)) q <= wr_data;
        end
        assign scr_q[s] = q;
    end

    for (genvar m = 0; m < NUM_MSK; m++) begin : g_msk
        localparam word_t KEEP = slot_mask(m, CNT_LO_W);
        word_t q;
        logic  hit;
        assign hit = wr_ok && wr_cls == CLS_MASK && wr_slot == 4'(m);
        if (m == SL_EXC_SUM || m == SL_EXC_MASK) begin : g_cow
            word_t setv;
            assign setv = (m == SL_EXC_SUM) ? sum_set : mask_set;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= (hit ? '0 : q) | setv;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (hit) q <= wr_data & KEEP;
            end
        end
        assign msk_q[m] = q;
    end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import crb_pkg::*;
#(
    parameter int NUM_SCR  = 4,
    parameter int CNT_LO_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_rd,
    input  logic                 acc_wr,
    input  logic [5:0]           acc_idx,
    input  logic [63:0]          acc_wdata,
    input  logic [63:0]          exc_sum_set,
    input  logic [63:0]          exc_mask_set,
    input  logic [4*64-1:0]      ro_status,
    output logic [63:0]          acc_rdata,
    output logic                 acc_fault,
    output logic                 tlb_cmd_valid,
    output logic [2:0]           tlb_cmd_op,
    output logic [63:0]          tlb_cmd_data
);
    dec_t               dec;
    logic [CNT_LO_W-1:0] cnt;
    word_t              scr_q [NUM_SCR];
    word_t              msk_q [NUM_MSK];
    logic               rd_bad, wr_bad, wr_ok;
    word_t              rv;
    tlb_op_e            op_q;

    crb_decode #(.NUM_SCR(NUM_SCR)) u_dec (
        .idx (acc_idx),
        .dec (dec)
    );

    crb_cycle_ctr #(.W(CNT_LO_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .cnt (cnt)
    );

    assign rd_bad = acc_rd && (dec.cls == CLS_NONE || dec.cls == CLS_WO);
    assign wr_bad = acc_wr && (dec.cls == CLS_NONE || dec.cls == CLS_RO);
    assign wr_ok  = acc_wr && !wr_bad;

    crb_store #(.NUM_SCR(NUM_SCR), .CNT_LO_W(CNT_LO_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_ok),
        .wr_cls   (dec.cls),
        .wr_slot  (dec.slot),
        .wr_data  (acc_wdata),
        .sum_set  (exc_sum_set),
        .mask_set (exc_mask_set),
        .scr_q    (scr_q),
        .msk_q    (msk_q)
    );

    // read selection, pre-write contents
    always_comb begin
        rv = '0;
        case (dec.cls)
            CLS_SCR: begin
                for (int s = 0; s < NUM_SCR; s++)
                    if (dec.slot == 4'(s)) rv = scr_q[s];
            end
            CLS_MASK: begin
                for (int m = 0; m < NUM_MSK; m++)
                    if (dec.slot == 4'(m)) rv = msk_q[m];
                if (dec.slot == 4'(SL_CYCLE)) rv = rv | word_t'(cnt);
            end
            CLS_RO: begin
                for (int r = 0; r < NUM_RO; r++)
                    if (dec.slot == 4'(r)) rv = ro_status[r*DW +: DW];
            end
            default: rv = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_rdata     <= '0;
            acc_fault     <= 1'b0;
            tlb_cmd_valid <= 1'b0;
            op_q          <= TLB_D_ALL;
            tlb_cmd_data  <= '0;
        end else begin
            acc_fault     <= rd_bad || wr_bad;
            tlb_cmd_valid <= wr_ok && dec.is_tlb;
            if (acc_rd) acc_rdata <= rd_bad ? '0 : rv;
            if (wr_ok && dec.is_tlb) begin
                op_q         <= dec.op;
                tlb_cmd_data <= acc_wdata;
            end
        end
    end

    assign tlb_cmd_op = op_q;
endmodule

// File: rtl/crb_checker.sv
module crb_checker
    import crb_pkg::*;
#(
    parameter int NUM_SCR  = 4,
    parameter int CNT_LO_W = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_rd,
    input logic        acc_wr,
    input logic [5:0]  acc_idx,
    input logic [63:0] acc_wdata,
    input logic [63:0] acc_rdata,
    input logic        acc_fault,
    input logic        tlb_cmd_valid,
    input logic [2:0]  tlb_cmd_op,
    input logic [63:0] tlb_cmd_data
);
    function automatic logic in_rng(input logic [5:0] i, input int lo, input int hi);
        return int'(i) >= lo && int'(i) <= hi;
    endfunction

    function automatic logic unassigned(input logic [5:0] i);
        return (int'(i) >= NUM_SCR && int'(i) < MSK_BASE) ||
               in_rng(i, MSK_BASE + NUM_MSK, RO_BASE - 1) ||
               in_rng(i, RO_BASE + NUM_RO, WO_BASE - 1) ||
               in_rng(i, WO_BASE + NUM_WO, TLB_BASE - 1) ||
               int'(i) >= TLB_BASE + NUM_TLB;
    endfunction

    logic [5:0] idx_d;
    word_t      keep_d;
    always_ff @(posedge clk) idx_d <= acc_idx;
    assign keep_d = slot_mask(int'(idx_d) - MSK_BASE, CNT_LO_W);

    assert_fault_after_access_R10: assert property (@(posedge clk) disable iff (rst)
        acc_fault |-> $past(acc_rd || acc_wr));

    assert_cmd_from_write_R8: assert property (@(posedge clk) disable iff (rst)
        tlb_cmd_valid |-> ($past(acc_wr) && in_rng($past(acc_idx), TLB_BASE, TLB_BASE + NUM_TLB - 1)
                           && tlb_cmd_data == $past(acc_wdata)
                           && tlb_cmd_op == 3'($past(acc_idx) - 6'(TLB_BASE))));

    assert_wo_read_faults_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && (in_rng(acc_idx, WO_BASE, WO_BASE + NUM_WO - 1) ||
                    in_rng(acc_idx, TLB_BASE, TLB_BASE + NUM_TLB - 1)))
        |=> (acc_fault && acc_rdata == '0));

    assert_ro_write_faults_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && in_rng(acc_idx, RO_BASE, RO_BASE + NUM_RO - 1)) |=> acc_fault);

    assert_unassigned_faults_R9: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd || acc_wr) && unassigned(acc_idx)) |=> acc_fault);

    assert_mask_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && in_rng(acc_idx, MSK_BASE, MSK_BASE + 10)) |=> ((acc_rdata & ~keep_d) == '0));
endmodule

bind ctrl_reg_bank crb_checker #(.NUM_SCR(NUM_SCR), .CNT_LO_W(CNT_LO_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .acc_rd        (acc_rd),
    .acc_wr        (acc_wr),
    .acc_idx       (acc_idx),
    .acc_wdata     (acc_wdata),
    .acc_rdata     (acc_rdata),
    .acc_fault     (acc_fault),
    .tlb_cmd_valid (tlb_cmd_valid),
    .tlb_cmd_op    (tlb_cmd_op),
    .tlb_cmd_data  (tlb_cmd_data)
);

// File: tb/test_ctrl_reg_bank.sv
module test_ctrl_reg_bank;
    localparam int NS = 4;
    localparam int LW = 8;
    localparam int K_NONE = 0, K_SCR = 1, K_MSK = 2, K_EXC = 3, K_CYC = 4,
                   K_RO = 5, K_WO = 6, K_TLB = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         rd = 0, wr = 0;
    logic [5:0]   idx = '0;
    logic [63:0]  wdata = '0, sum_set = '0, msk_set = '0;
    logic [255:0] ro_bus = '0;
    logic [63:0]  rdata, tdata;
    logic         fault, tv;
    logic [2:0]   top;

    int vectors = 0, miscompares = 0;
    logic [63:0] model [64];
    logic [63:0] tb_cyc;

    ctrl_reg_bank #(.NUM_SCR(NS), .CNT_LO_W(LW)) i_ctrl_reg_bank (
        .clk (clk), .rst (rst), .acc_rd (rd), .acc_wr (wr), .acc_idx (idx),
        .acc_wdata (wdata), .exc_sum_set (sum_set), .exc_mask_set (msk_set),
        .ro_status (ro_bus), .acc_rdata (rdata), .acc_fault (fault),
        .tlb_cmd_valid (tv), .tlb_cmd_op (top), .tlb_cmd_data (tdata)
    );

    // bench time base for the spliced counter (R5)
    always @(posedge clk) begin
        if (rst) tb_cyc <= '0;
        else     tb_cyc <= tb_cyc + 64'd1;
    end

    function automatic int kind_of(input int i);
        if (i < NS) return K_SCR;
        if (i >= 16 && i <= 26) return K_MSK;
        if (i == 27 || i == 28) return K_EXC;
        if (i == 29) return K_CYC;
        if (i >= 32 && i <= 35) return K_RO;
        if (i >= 40 && i <= 44) return K_WO;
        if (i >= 48 && i <= 53) return K_TLB;
        return K_NONE;
    endfunction

    function automatic string req_of(input int k);
        case (k)
            K_SCR: return "R2";
            K_MSK: return "R3";
            K_EXC: return "R4";
            K_CYC: return "R5";
            K_RO:  return "R6";
            K_WO:  return "R7";
            K_TLB: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [63:0] keep_of(input int i);
        case (i)
            16, 17: return 64'hf;
            18:     return 64'h18;
            19:     return 64'hff_ffff_0300;
            20, 21: return 64'hffff_ffff_c000_0000;
            22:     return 64'h1ffb;
            23, 24: return 64'h3f;
            25:     return 64'h7f0;
            26:     return 64'hfe00_0000_0000_0000;
            29:     return ~((64'd1 << LW) - 64'd1);
            default: return '1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int i, input logic [63:0] d);
        int k;
        k = kind_of(i);
        @(negedge clk); wr = 1'b1; idx = 6'(i); wdata = d;
        @(negedge clk); wr = 1'b0;
        chk(req_of(k), 64'(fault), 64'(k == K_NONE || k == K_RO), "write fault");
        chk(req_of(k), 64'(tv), 64'(k == K_TLB), "command strobe");
        if (k == K_TLB) begin
            chk("R8", 64'(top), 64'(i - 48), "command op");
            chk("R8", tdata, d, "command data");
            @(negedge clk);
            chk("R8", 64'(tv), 64'd0, "strobe width");
        end
        if (k == K_SCR || k == K_MSK || k == K_CYC) model[i] = d & keep_of(i);
        else if (k == K_EXC) model[i] = '0;
    endtask

    task automatic do_read(input int i);
        int k;
        logic [63:0] e;
        logic f;
        k = kind_of(i);
        @(negedge clk); rd = 1'b1; idx = 6'(i);
        f = (k == K_NONE || k == K_WO || k == K_TLB);
        if (f)              e = '0;
        else if (k == K_RO) e = ro_bus[(i-32)*64 +: 64];
        else if (k == K_CYC) e = model[i] | (tb_cyc & ((64'd1 << LW) - 64'd1));
        else                e = model[i];
        @(negedge clk); rd = 1'b0;
        chk(req_of(k), 64'(fault), 64'(f), "read fault");
        chk(req_of(k), rdata, e, "read data");
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", rdata, 64'd0, "rdata after reset");
        chk("R1", 64'(fault), 64'd0, "fault after reset");
        chk("R1", 64'(tv), 64'd0, "strobe after reset");
        for (int i = 0; i < 64; i++) do_read(i);

        // sweep A: varied pattern over every index
        ro_bus = {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
                  64'h9999_aaaa_bbbb_cccc, 64'hdddd_eeee_ffff_0123};
        for (int i = 0; i < 64; i++)
            do_write(i, 64'ha5c3_96f0_0f69_3c5a ^ (64'h0101_0101_0101_0101 * 64'(i)));
        for (int i = 0; i < 64; i++) do_read(i);

        // sweep B: all ones
        ro_bus = ~ro_bus;
        for (int i = 0; i < 64; i++) do_write(i, '1);
        for (int i = 0; i < 64; i++) do_read(i);

        // sweep C: all zeros
        ro_bus = {4{64'h0f0f_f0f0_3cc3_c33c}};
        for (int i = 0; i < 64; i++) do_write(i, '0);
        for (int i = 0; i < 64; i++) do_read(i);

        // R4: hardware set, clear on write, set racing the clear
        @(negedge clk); sum_set = 64'h8000_0000_0000_0041;
        @(negedge clk); sum_set = '0;
        model[27] = 64'h8000_0000_0000_0041;
        do_read(27);
        do_write(27, 64'hffff_ffff_ffff_ffff);
        do_read(27);
        @(negedge clk); wr = 1'b1; idx = 6'd28; wdata = '1; msk_set = 64'h0000_0300_0000_0002;
        @(negedge clk); wr = 1'b0; msk_set = '0;
        chk("R4", 64'(fault), 64'd0, "clear write fault");
        model[28] = 64'h0000_0300_0000_0002;
        do_read(28);

        // R5: counter splice across a wrap, upper-only store
        do_write(29, 64'h1234_5678_9abc_def0);
        do_read(29);
        do_read(29);
        repeat (300) @(negedge clk);
        do_read(29);

        // R10: fault is a pulse, read data holds
        do_write(1, 64'hdead_beef_cafe_f00d);
        do_read(1);
        repeat (3) @(negedge clk);
        chk("R10", rdata, 64'hdead_beef_cafe_f00d, "rdata hold");
        do_read(63);
        @(negedge clk);
        chk("R10", 64'(fault), 64'd0, "fault pulse width");

        // R11: read and write together return old contents
        do_write(0, 64'h0123_4567_89ab_cdef);
        @(negedge clk); rd = 1'b1; wr = 1'b1; idx = 6'd0; wdata = 64'hfedc_ba98_7654_3210;
        @(negedge clk); rd = 1'b0; wr = 1'b0;
        chk("R11", rdata, 64'h0123_4567_89ab_cdef, "read during write");
        model[0] = 64'hfedc_ba98_7654_3210;
        do_read(0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule